// File: doc/BRIEF.md
# CD Sector Synchronizer and Descrambler

This block sits between an optical disc front end and a sector buffer RAM. It takes a stream of bytes, each with an erasure flag from the upstream error decoder, and finds where each 2352-byte sector begins by matching the 12-byte sync pattern in the data. Once aligned, it keeps a sector position counter that runs on its own. This flywheel lets it carry on through sectors whose sync is missing or damaged. Every byte of an aligned sector is written to the buffer through a write port, in arrival order. The header, subheader, user data and parity bytes are descrambled on the way. The erasure flag goes into a ninth data bit.

Pattern detection and flywheel interpolation have separate enable pins, so firmware can run either one alone or both. A third pin picks between a 9-bit buffer, which stores the flag, and an 8-bit buffer, which stores zero in the ninth bit. Write addresses count up from a sector base address. The base is sampled when each sector's first byte is written, so the controller can point each sector at a new slot.

Both data paths are valid/ready. An input byte is taken on a cycle with `in_valid` and `in_ready` both high. `in_ready` is high when the single output register is empty or is being drained in that cycle. While `wr_valid` is high and `wr_ready` is low, every write-port output holds still and no input is taken. No byte is dropped or duplicated. A sync decision needs the 11 bytes before the one being judged, so a sector's bytes leave the block 12 accepted bytes after they enter it.

Top module: `cd_sector_sync`

## Requirements
- R1: In search mode nothing is written. The pattern 00h, ten FFh, 00h seen with `det_en` high sets `locked`. Those 12 bytes become positions 0..11 of the first stored sector.
- R2: Each byte of a locked sector (positions 0..2351) is written once, in arrival order, at `wr_addr` = base + position (modulo 2^16). The base is the value of `base_addr` sampled when position 0 is written.
- R3: `wr_first` is high on the write of position 0 and low on every other write.
- R4: Positions 0..11 are stored unchanged. Each later byte is XORed with a key byte from a 15-bit LFSR (x^15 + x + 1). The LFSR is loaded with 0001h at position 12. Its output is register bit 0, taken 8 times per byte with the first bit in the byte's LSB. The key for position 12 is therefore 01h.
- R5: With `flag_en` high, `wr_data[8]` is the input flag of that byte. With `flag_en` low it is 0. `wr_data[7:0]` is the byte.
- R6: While locked, a sync found at the expected boundary with `det_en` high clears the miss count. A sync pattern anywhere else in a sector is ignored.
- R7: With `interp_en` high, a missing sync at the boundary starts the next sector anyway. After three boundaries in a row without sync, lock is dropped at the third boundary, and nothing is written until the next detection.
- R8: With `interp_en` low, the first boundary without sync drops lock.
- R9: With `det_en` low, a valid sync pattern never sets `locked`.
- R10: `in_ready` = !`wr_valid` || `wr_ready`. While `wr_valid` is high and `wr_ready` is low, `wr_addr`, `wr_data` and `wr_first` hold, and no stored byte is lost under any stall pattern.
- R11: After reset `wr_valid` and `locked` are 0 and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input byte valid |
| in_ready | output | 1 | Input byte accepted when high with in_valid |
| in_data | input | 8 | Raw byte from the disc front end |
| in_flag | input | 1 | Erasure flag of in_data |
| det_en | input | 1 | Enable sync pattern detection |
| interp_en | input | 1 | Enable flywheel sync interpolation |
| flag_en | input | 1 | Store flag in bit 8 (9-bit buffer mode) |
| base_addr | input | 16 | Buffer address of the next sector's first byte |
| wr_valid | output | 1 | Buffer write valid |
| wr_ready | input | 1 | Buffer accepts the write |
| wr_addr | output | 16 | Buffer write address |
| wr_data | output | 9 | Flag bit and stored byte |
| wr_first | output | 1 | Marks the write of a sector's first byte |
| locked | output | 1 | Sector alignment held |

## Verification
The hold assertion assumes the buffer can stall for any length of time. The bench therefore drops `wr_ready` on a random quarter of cycles and leaves random gaps in `in_valid`. The lock and boundary properties assume that `det_en`, `interp_en` and `flag_en` are set while the block is in reset and then stay fixed, and the bench changes them only there. The address properties assume `base_addr` changes only between sector starts, and the bench updates it at the first input byte of each sector. That is at least 12 bytes before the value is sampled.

// File: rtl/cdsync_pkg.sv
package cdsync_pkg;
  localparam int SYNC_LEN = 12;
  localparam logic [14:0] LFSR_SEED = 15'h0001;

  function automatic logic [7:0] sync_byte(input int unsigned idx);
    return (idx == 0 || idx == SYNC_LEN - 1) ? 8'h00 : 8'hFF;
  endfunction

  function automatic logic [7:0] lfsr_key(input logic [14:0] st);
    logic [14:0] s;
    logic [7:0] k;
    s = st;
    k = '0;
    for (int b = 0; b < 8; b++) begin
      k[b] = s[0];
      s = {s[0] ^ s[1], s[14:1]};
    end
    return k;
  endfunction

  function automatic logic [14:0] lfsr_adv8(input logic [14:0] st);
    logic [14:0] s;
    s = st;
    for (int b = 0; b < 8; b++) s = {s[0] ^ s[1], s[14:1]};
    return s;
  endfunction
endpackage

// File: rtl/cdsync_window.sv
module cdsync_window
  import cdsync_pkg::*;
#(
  parameter int DEPTH = SYNC_LEN,
  parameter int W     = 9
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         shift,
  input  logic [W-1:0] din,
  output logic [W-1:0] oldest,
  output logic         match
);
  logic [W-1:0] win [DEPTH];
  logic [DEPTH-1:0] hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) win[i] <= '0;
    end else if (shift) begin
      for (int i = 0; i < DEPTH - 1; i++) win[i] <= win[i+1];
      win[DEPTH-1] <= din;
    end
  end

  // Candidate window is the stored bytes 1..DEPTH-1 plus the arriving byte.
  for (genvar i = 0; i < DEPTH; i++) begin : g_cmp
    if (i < DEPTH - 1) begin : g_stored
      assign hit[i] = (win[i+1][7:0] == sync_byte(i));
    end else begin : g_new
      assign hit[i] = (din[7:0] == sync_byte(i));
    end
  end

  assign match  = &hit;
  assign oldest = win[0];
endmodule

// File: rtl/cdsync_lock.sv
module cdsync_lock #(
  parameter int SECTOR_BYTES = 2352,
  parameter int MISS_LIMIT   = 3,
  localparam int POS_W  = $clog2(SECTOR_BYTES),
  localparam int MISS_W = $clog2(MISS_LIMIT + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step,
  input  logic             match,
  input  logic             det_en,
  input  logic             interp_en,
  output logic             locked,
  output logic [POS_W-1:0] pos
);
  localparam logic [POS_W-1:0] LAST = POS_W'(SECTOR_BYTES - 1);

  logic [MISS_W-1:0] miss;
  logic [MISS_W-1:0] miss_inc;
  logic              found;

  assign miss_inc = miss + 1'b1;
  assign found    = det_en && match;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      locked <= 1'b0;
      pos    <= '0;
      miss   <= '0;
    end else if (step) begin
      if (!locked) begin
        if (found) begin
          locked <= 1'b1;
          pos    <= '0;
          miss   <= '0;
        end
      end else if (pos == LAST) begin
        if (found) begin
          pos  <= '0;
          miss <= '0;
        end else if (interp_en && (miss_inc < MISS_W'(MISS_LIMIT))) begin
          pos  <= '0;
          miss <= miss_inc;
        end else begin
          locked <= 1'b0;
          pos    <= '0;
          miss   <= '0;
        end
      end else begin
        pos <= pos + 1'b1;
      end
    end
  end

  p_miss_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
    locked |-> miss < MISS_W'(MISS_LIMIT));

  p_pos_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    pos <= LAST);

  p_lock_source_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked) |-> $past(det_en && match && step));

  p_drop_boundary_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(locked) |-> $past(pos) == LAST);
endmodule

// File: rtl/cdsync_scrambler.sv
module cdsync_scrambler
  import cdsync_pkg::*;
#(
  parameter int SECTOR_BYTES = 2352,
  localparam int POS_W = $clog2(SECTOR_BYTES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step,
  input  logic [POS_W-1:0] pos,
  input  logic [7:0]       din,
  output logic [7:0]       dout
);
  logic [14:0] state;
  logic        payload;

  assign payload = (pos >= POS_W'(SYNC_LEN));
  assign dout    = payload ? (din ^ lfsr_key(state)) : din;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= LFSR_SEED;
    end else if (step) begin
      if (pos == POS_W'(SYNC_LEN - 1)) state <= LFSR_SEED;
      else if (payload)                state <= lfsr_adv8(state);
    end
  end

  p_seed_at_payload_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (step && pos == POS_W'(SYNC_LEN)) |-> state == LFSR_SEED);
endmodule

// File: rtl/cd_sector_sync.sv
module cd_sector_sync
  import cdsync_pkg::*;
#(
  parameter int ADDR_W       = 16,
  parameter int SECTOR_BYTES = 2352,
  parameter int MISS_LIMIT   = 3,
  localparam int POS_W = $clog2(SECTOR_BYTES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [7:0]        in_data,
  input  logic              in_flag,
  input  logic              det_en,
  input  logic              interp_en,
  input  logic              flag_en,
  input  logic [ADDR_W-1:0] base_addr,
  output logic              wr_valid,
  input  logic              wr_ready,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [8:0]        wr_data,
  output logic              wr_first,
  output logic              locked
);
  logic             accept;
  logic             emit;
  logic [8:0]       old_byte;
  logic             match;
  logic [POS_W-1:0] pos;
  logic [7:0]       plain;
  logic [ADDR_W-1:0] base_q;
  logic [ADDR_W-1:0] base_now;

  assign in_ready = !wr_valid || wr_ready;
  assign accept   = in_valid && in_ready;
  assign emit     = accept && locked;
  assign base_now = (pos == '0) ? base_addr : base_q;

  cdsync_window #(.DEPTH(SYNC_LEN), .W(9)) u_window (
    .clk    (clk),
    .rst_n  (rst_n),
    .shift  (accept),
    .din    ({in_flag, in_data}),
    .oldest (old_byte),
    .match  (match)
  );

  cdsync_lock #(.SECTOR_BYTES(SECTOR_BYTES), .MISS_LIMIT(MISS_LIMIT)) u_lock (
    .clk       (clk),
    .rst_n     (rst_n),
    .step      (accept),
    .match     (match),
    .det_en    (det_en),
    .interp_en (interp_en),
    .locked    (locked),
    .pos       (pos)
  );

  cdsync_scrambler #(.SECTOR_BYTES(SECTOR_BYTES)) u_scr (
    .clk   (clk),
    .rst_n (rst_n),
    .step  (emit),
    .pos   (pos),
    .din   (old_byte[7:0]),
    .dout  (plain)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_valid <= 1'b0;
      wr_addr  <= '0;
      wr_data  <= '0;
      wr_first <= 1'b0;
      base_q   <= '0;
    end else if (emit) begin
      wr_valid <= 1'b1;
      wr_addr  <= base_now + ADDR_W'(pos);
      wr_data  <= {flag_en & old_byte[8], plain};
      wr_first <= (pos == '0);
      if (pos == '0) base_q <= base_addr;
    end else if (wr_ready) begin
      wr_valid <= 1'b0;
    end
  end

  // Address of the last accepted write, for the sequence check.
  logic [ADDR_W-1:0] prev_addr;
  logic              have_prev;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_addr <= '0;
      have_prev <= 1'b0;
    end else if (wr_valid && wr_ready) begin
      prev_addr <= wr_addr;
      have_prev <= 1'b1;
    end
  end

  p_hold_stall_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wr_ready) |=> wr_valid && $stable(wr_addr) && $stable(wr_data)
                                && $stable(wr_first));

  p_addr_sequence_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wr_first && have_prev) |-> wr_addr == prev_addr + 1'b1);

  p_no_write_unlocked_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!locked && !$past(locked)) |-> !$rose(wr_valid));
endmodule

// File: tb/cd_sector_sync_tb.sv
module cd_sector_sync_tb;
  localparam int NBYTES = 2352;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [7:0]  in_data = '0;
  logic        in_flag = 1'b0;
  logic        det_en = 1'b1;
  logic        interp_en = 1'b1;
  logic        flag_en = 1'b1;
  logic [15:0] base_addr = '0;
  logic        wr_valid;
  logic        wr_ready = 1'b1;
  logic [15:0] wr_addr;
  logic [8:0]  wr_data;
  logic        wr_first;
  logic        locked;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;
  bit stall_mode = 0;
  logic [25:0] exp_q[$];

  always #5 clk = ~clk;

  cd_sector_sync u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_flag(in_flag), .det_en(det_en), .interp_en(interp_en),
    .flag_en(flag_en), .base_addr(base_addr), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_addr(wr_addr), .wr_data(wr_data), .wr_first(wr_first), .locked(locked)
  );

  // Scenario vectors: det, interp, flag, stall, base[15:0], bad[4:0], store[4:0]
  localparam logic [29:0] SCEN [5] = '{
    {1'b1, 1'b1, 1'b1, 1'b0, 16'h0000, 5'b00000, 5'b11111},
    {1'b1, 1'b1, 1'b0, 1'b0, 16'h1234, 5'b00110, 5'b11111},
    {1'b1, 1'b1, 1'b1, 1'b0, 16'hF000, 5'b01110, 5'b10111},
    {1'b1, 1'b0, 1'b1, 1'b0, 16'h0100, 5'b00100, 5'b11011},
    {1'b1, 1'b1, 1'b1, 1'b1, 16'h2000, 5'b10010, 5'b11111}
  };

  function automatic logic [7:0] pat(input int p);
    return (p == 0 || p == 11) ? 8'h00 : 8'hFF;
  endfunction

  // Returns {next_state, key} for the x^15+x+1 generator, LSB first.
  function automatic logic [22:0] key_step(input logic [14:0] st);
    logic [14:0] s;
    logic [7:0] k;
    s = st;
    for (int b = 0; b < 8; b++) begin
      k[b] = s[0];
      s = {s[0] ^ s[1], s[14:1]};
    end
    return {s, k};
  endfunction

  task automatic fail_line(input string req, input string what, input int act, input int exp);
    n_fail++;
    $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
  endtask

  always @(posedge clk) begin
    #2;
    wr_ready = stall_mode ? ($urandom % 4 != 0) : 1'b1;
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      n_tests++;
      if (in_ready !== (!wr_valid || wr_ready))
        fail_line("R10", "in_ready", int'(in_ready), int'(!wr_valid || wr_ready));
      if (wr_valid && wr_ready) begin
        n_tests++;
        if (exp_q.size() == 0) begin
          fail_line("R1", "unexpected write addr", int'(wr_addr), -1);
        end else begin
          logic [25:0] e;
          e = exp_q.pop_front();
          if (wr_addr !== e[24:9])
            fail_line("R2", "wr_addr", int'(wr_addr), int'(e[24:9]));
          else if (wr_first !== e[25])
            fail_line("R3", "wr_first", int'(wr_first), int'(e[25]));
          else if (wr_data[7:0] !== e[7:0])
            fail_line("R4", "wr_data byte", int'(wr_data[7:0]), int'(e[7:0]));
          else if (wr_data[8] !== e[8])
            fail_line("R5", "wr_data flag", int'(wr_data[8]), int'(e[8]));
        end
      end
    end
  end

  task automatic send_byte(input logic [7:0] d, input logic f);
    if (stall_mode && ($urandom % 4 == 0)) begin
      in_valid = 1'b0;
      @(posedge clk); #1;
    end
    in_valid = 1'b1;
    in_data  = d;
    in_flag  = f;
    do @(negedge clk); while (!in_ready);
    @(posedge clk); #1;
    in_valid = 1'b0;
  endtask

  task automatic send_sector(input bit good, input bit store, input logic [15:0] base,
                             input bit inject);
    logic [14:0] s;
    s = 15'h0001;
    base_addr = base;
    for (int p = 0; p < NBYTES; p++) begin
      logic [7:0] wb, plain;
      logic [22:0] ks;
      logic f;
      f = ($urandom % 8 == 0);
      if (p < 12) begin
        wb = pat(p);
        if (!good && p == 5) wb = 8'h7E;
        plain = wb;
      end else begin
        ks = key_step(s);
        s  = ks[22:8];
        if (inject && p >= 100 && p < 112) begin
          wb = pat(p - 100);
          plain = wb ^ ks[7:0];
        end else begin
          plain = 8'($urandom);
          wb = plain ^ ks[7:0];
        end
      end
      if (store) exp_q.push_back({(p == 0), base + 16'(p), flag_en ? f : 1'b0, plain});
      send_byte(wb, f);
    end
  endtask

  task automatic preamble();
    for (int i = 0; i < 20; i++) send_byte(8'(1 + $urandom % 200), 1'b0);
  endtask

  task automatic finish_run(input string req, input bit exp_lock);
    for (int i = 0; i < 12; i++) send_byte(pat(i), 1'b0);
    repeat (60) @(posedge clk);
    @(negedge clk);
    n_tests++;
    if (exp_q.size() != 0) fail_line(req, "writes missing", exp_q.size(), 0);
    n_tests++;
    if (locked !== exp_lock) fail_line(req, "locked at end", int'(locked), int'(exp_lock));
    exp_q.delete();
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    in_valid = 1'b0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_fail++;
      $display("FAIL R10 watchdog: actual running expected finished");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    // R11: reset state
    do_reset();
    @(negedge clk);
    n_tests++;
    if (wr_valid !== 1'b0) fail_line("R11", "wr_valid", int'(wr_valid), 0);
    n_tests++;
    if (locked !== 1'b0) fail_line("R11", "locked", int'(locked), 0);
    n_tests++;
    if (in_ready !== 1'b1) fail_line("R11", "in_ready", int'(in_ready), 1);

    // Vector table: R1..R8 and R10 under stalls
    for (int i = 0; i < 5; i++) begin
      logic [29:0] v;
      v = SCEN[i];
      det_en = v[29]; interp_en = v[28]; flag_en = v[27];
      do_reset();
      stall_mode = v[26];
      preamble();
      for (int s = 0; s < 5; s++)
        send_sector(!v[5+s], v[s], v[25:10] + 16'(s) * 16'h0930, 1'b0);
      finish_run("R7", 1'b1);
      stall_mode = 0;
    end

    // R9: detection disabled never locks, nothing written
    det_en = 0; interp_en = 1; flag_en = 1;
    do_reset();
    preamble();
    send_sector(1'b1, 1'b0, 16'h4000, 1'b0);
    send_sector(1'b1, 1'b0, 16'h5000, 1'b0);
    finish_run("R9", 1'b0);

    // R6: sync pattern inside payload while locked is ignored
    det_en = 1; interp_en = 0; flag_en = 1;
    do_reset();
    preamble();
    send_sector(1'b1, 1'b1, 16'h8000, 1'b0);
    send_sector(1'b1, 1'b1, 16'h9000, 1'b1);
    send_sector(1'b1, 1'b1, 16'hA000, 1'b0);
    finish_run("R6", 1'b1);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule